// File: doc/BRIEF.md
# Prioritized Paged Memory-Map Decoder

This block turns every CPU bus cycle on a 16-bit address bus into exactly one chip select. It chooses among six resources: a debug ROM, the internal register block, RAM, EEPROM, on-chip flash and external memory. Where regions overlap, a fixed precedence decides. The register block is 1K byte long and can be moved to any 2K byte boundary. A 16K byte window at $8000–$BFFF pages through 128K bytes of flash, which is built as four 32K byte arrays. For each flash access the block also produces the 17-bit physical flash address.

Two control registers live inside the register block: a relocation register and a program-page register. The CPU writes them with ordinary bus writes. The decode itself is combinational from the address, the strobes and these two registers. A write changes the mapping only from the following bus cycle.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the register block occupies $0000–$03FF and the page register holds 0, so a valid access to $8000 selects flash with physical address 0.
- R2: On a cycle with bus_valid high exactly one bit of cs_onehot is set. With bus_valid low, cs_onehot and flash_paddr are both zero. The chip-select bits are: bit 0 debug ROM, bit 1 register block, bit 2 RAM, bit 3 EEPROM, bit 4 flash, bit 5 external.
- R3: Where regions overlap, the selected resource is the first present in this order: debug ROM, register block, RAM, EEPROM, flash, external. RAM spans $2000–$3FFF and EEPROM spans $1000–$2FFF, so $2000–$2FFF selects RAM.
- R4: The register block is hit when address bits 15:11 equal the 5-bit relocation field and address bit 10 is 0. The upper 1K of that 2K region falls through to lower-precedence resources.
- R5: Inside the register block, RAM, EEPROM and flash are never selected, even where they would otherwise decode.
- R6: Array 11 is fixed at $4000–$7FFF and $C000–$FFFF. Its physical address is {2'b11, addr[15], addr[13:0]}.
- R7: A flash access in $8000–$BFFF has physical address {page, addr[13:0]}. Page bits 2:1 pick the array and bit 0 picks its 16K half, and any of the four arrays can be reached, including array 11.
- R8: While debug_active is high, $FF00–$FFFF selects the debug ROM, overriding flash. While it is low, those addresses decode normally.
- R9: A write with bus_valid and bus_wr high that hits the register block writes the relocation field from bus_wdata[7:3] at offset $011, or the page register from bus_wdata[2:0] at offset $030. The write cycle itself decodes with the old mapping, and the new value takes effect from the next clock.
- R10: Any address that no internal resource claims selects external memory; with the default map this is $0000–$0FFF outside the register block.
- R11: flash_paddr is zero whenever the flash chip select is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus cycle in progress |
| bus_wr | input | 1 | Bus cycle is a write |
| bus_addr | input | 16 | CPU logical address |
| bus_wdata | input | 8 | CPU write data |
| debug_active | input | 1 | Debug ROM mapped in when high |
| cs_onehot | output | 6 | One-hot chip selects (debug, register, RAM, EEPROM, flash, external) |
| flash_paddr | output | 17 | Physical flash byte address |

## Verification
Every one of the 65536 addresses is decoded under four configurations. These put the register block over external space, over EEPROM with its upper half falling through, over fixed flash next to the debug ROM, and over RAM. The page register varies across them, and each full sweep separates a wrong precedence, a wrong window bank or a wrong fixed-region half at every address. A sparse sweep with bus_valid low shows that nothing is selected when idle. Register writes are checked on both sides of the clock edge, which shows that the old mapping holds during the write and the new one applies immediately afterwards.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int NUM_CS  = 6;
  localparam int CS_DBG  = 0;
  localparam int CS_REG  = 1;
  localparam int CS_RAM  = 2;
  localparam int CS_EE   = 3;
  localparam int CS_FLS  = 4;
  localparam int CS_EXT  = 5;
  localparam int AW      = 16;
  localparam int RELOC_W = 5;
  localparam int PAGE_W  = 3;
  localparam int WIN_W   = 14;
  localparam int PA_W    = PAGE_W + WIN_W;
  localparam int OFS_W   = AW - RELOC_W - 1;
endpackage

// File: rtl/mm_ctrl_regs.sv
module mm_ctrl_regs
  import memmap_pkg::*;
#(
  parameter logic [OFS_W-1:0] RELOC_OFS = 10'h011,
  parameter logic [OFS_W-1:0] PAGE_OFS  = 10'h030
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_wr,
  input  logic               reg_sel,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [7:0]         wdata,
  output logic [RELOC_W-1:0] reloc,
  output logic [PAGE_W-1:0]  page
);
  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic               wr_reloc, wr_page;
  logic [RELOC_W-1:0] reloc_d, reloc_q;
  logic [PAGE_W-1:0]  page_d, page_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    wr_reloc = bus_valid && bus_wr && reg_sel && (ofs == RELOC_OFS);
    wr_page  = bus_valid && bus_wr && reg_sel && (ofs == PAGE_OFS);
    reloc_d  = wr_reloc ? wdata[7:8-RELOC_W] : reloc_q;
    page_d   = wr_page  ? wdata[PAGE_W-1:0]  : page_q;
  end

  always_ff @(posedge clk or negedge rst_int_n)
    if (!rst_int_n) begin
      reloc_q <= '0;
      page_q  <= '0;
    end else begin
      reloc_q <= reloc_d;
      page_q  <= page_d;
    end

  assign reloc = reloc_q;
  assign page  = page_q;

  // R9: without a write the mapping registers hold
  p_reloc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reloc |=> $stable(reloc));
  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_page |=> $stable(page));
endmodule

// File: rtl/mm_region_hits.sv
module mm_region_hits
  import memmap_pkg::*;
#(
  parameter logic [AW-1:0] RAM_BASE = 16'h2000,
  parameter int            RAM_SIZE = 8192,
  parameter logic [AW-1:0] EE_BASE  = 16'h1000,
  parameter int            EE_SIZE  = 8192,
  parameter logic [7:0]    DBG_PAGE = 8'hFF
) (
  input  logic [AW-1:0]      addr,
  input  logic [RELOC_W-1:0] reloc,
  input  logic               debug_active,
  output logic [NUM_CS-1:0]  hit
);
  localparam logic [AW:0] RAM_END = {1'b0, RAM_BASE} + AW'(RAM_SIZE);
  localparam logic [AW:0] EE_END  = {1'b0, EE_BASE}  + AW'(EE_SIZE);

  always_comb begin
    hit         = '0;
    hit[CS_DBG] = debug_active && (addr[AW-1:AW-8] == DBG_PAGE);
    hit[CS_REG] = (addr[AW-1:AW-RELOC_W] == reloc) && !addr[AW-RELOC_W-1];
    hit[CS_RAM] = (addr >= RAM_BASE) && ({1'b0, addr} < RAM_END);
    hit[CS_EE]  = (addr >= EE_BASE)  && ({1'b0, addr} < EE_END);
    hit[CS_FLS] = (addr[AW-1:WIN_W] != 2'b00);
    hit[CS_EXT] = 1'b1;
  end
endmodule

// File: rtl/mm_select.sv
module mm_select
  import memmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              debug_active,
  input  logic [AW-1:0]     addr,
  input  logic [PAGE_W-1:0] page,
  input  logic [NUM_CS-1:0] hit,
  output logic [NUM_CS-1:0] cs,
  output logic [PA_W-1:0]   paddr
);
  logic [NUM_CS-1:0] win;
  logic              taken;

  // lowest index is highest precedence
  always_comb begin
    win   = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hit[i] && !taken) begin
        win[i] = 1'b1;
        taken  = 1'b1;
      end
    end
    cs = bus_valid ? win : '0;
  end

  always_comb begin
    paddr = '0;
    if (cs[CS_FLS]) begin
      if (addr[AW-1:WIN_W] == 2'b10) paddr = {page, addr[WIN_W-1:0]};
      else                           paddr = {2'b11, addr[AW-1], addr[WIN_W-1:0]};
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(cs) == 1));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (cs == '0 && paddr == '0));
  p_dbg_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && debug_active && addr[AW-1:AW-8] == 8'hFF) |-> cs[CS_DBG]);
  p_fixed_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs[CS_FLS] && addr[AW-1:WIN_W] != 2'b10) |-> (paddr[PA_W-1:PA_W-2] == 2'b11));
  p_paddr_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cs[CS_FLS] |-> (paddr == '0));
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter logic [AW-1:0] RAM_BASE = 16'h2000,
  parameter int            RAM_SIZE = 8192,
  parameter logic [AW-1:0] EE_BASE  = 16'h1000,
  parameter int            EE_SIZE  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              debug_active,
  output logic [NUM_CS-1:0] cs_onehot,
  output logic [PA_W-1:0]   flash_paddr
);
  logic [RELOC_W-1:0] reloc;
  logic [PAGE_W-1:0]  page;
  logic [NUM_CS-1:0]  hit;

  mm_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_wr    (bus_wr),
    .reg_sel   (cs_onehot[CS_REG]),
    .ofs       (bus_addr[OFS_W-1:0]),
    .wdata     (bus_wdata),
    .reloc     (reloc),
    .page      (page)
  );

  mm_region_hits #(
    .RAM_BASE (RAM_BASE),
    .RAM_SIZE (RAM_SIZE),
    .EE_BASE  (EE_BASE),
    .EE_SIZE  (EE_SIZE)
  ) u_hits (
    .addr         (bus_addr),
    .reloc        (reloc),
    .debug_active (debug_active),
    .hit          (hit)
  );

  mm_select u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .debug_active (debug_active),
    .addr         (bus_addr),
    .page         (page),
    .hit          (hit),
    .cs           (cs_onehot),
    .paddr        (flash_paddr)
  );

  // R5: register block shadows storage resources
  p_reg_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[15:11] == reloc && !bus_addr[10])
      |-> !(cs_onehot[CS_RAM] || cs_onehot[CS_EE] || cs_onehot[CS_FLS]));
endmodule

// File: tb/memmap_decoder_bench.sv
`timescale 1ns/100ps
module memmap_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_wr, debug_active;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [5:0]  cs_onehot;
  logic [16:0] flash_paddr;

  int vectors = 0;
  int errors  = 0;
  int m_reloc = 0;
  int m_page  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  memmap_decoder u_memmap_decoder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .debug_active(debug_active),
    .cs_onehot(cs_onehot), .flash_paddr(flash_paddr)
  );

  function automatic int exp_idx(int a, int rl, bit dbg);
    if (dbg && a >= 65280)                    return 0;
    if ((a / 2048) == rl && (a % 2048) < 1024) return 1;
    if (a >= 8192 && a < 16384)               return 2;
    if (a >= 4096 && a < 12288)               return 3;
    if (a >= 16384)                           return 4;
    return 5;
  endfunction

  function automatic int exp_pa(int a, int pg);
    if (a >= 32768 && a < 49152) return pg * 16384 + (a % 16384);
    return 3 * 32768 + (a >= 49152 ? 16384 : 0) + (a % 16384);
  endfunction

  task automatic check(string tag, int a, bit vld);
    int ei, ecs, epa;
    ei  = exp_idx(a, m_reloc, debug_active);
    ecs = vld ? (1 << ei) : 0;
    epa = (vld && ei == 4) ? exp_pa(a, m_page) : 0;
    vectors++;
    if (cs_onehot !== 6'(ecs) || flash_paddr !== 17'(epa)) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s addr=%h cs=%b/%b paddr=%h/%h", tag, a[15:0],
                 cs_onehot, 6'(ecs), flash_paddr, 17'(epa));
    end
  endtask

  function automatic string tag_of(int a);
    case (exp_idx(a, m_reloc, debug_active))
      0: return "R8";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return (a >= 32768 && a < 49152) ? "R7" : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic sweep();
    for (int a = 0; a < 65536; a++) begin
      bus_addr = a[15:0];
      #1;
      check(tag_of(a), a, 1'b1);
    end
  endtask

  // R9: write through the register block, old map during, new map after
  task automatic reg_write(int ofs, bit [7:0] d);
    int a;
    @(negedge clk);
    a = m_reloc * 2048 + ofs;
    bus_addr = a[15:0]; bus_wdata = d; bus_wr = 1'b1; bus_valid = 1'b1;
    #1;
    check("R9", a, 1'b1);
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    if (ofs == 'h011) m_reloc = int'(d[7:3]);
    else              m_page  = int'(d[2:0]);
    check("R9", a, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_wr = 1'b0; debug_active = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset map
    bus_valid = 1'b1;
    bus_addr = 16'h0000; #1; check("R1", 'h0000, 1'b1);
    bus_addr = 16'h0400; #1; check("R1", 'h0400, 1'b1);
    bus_addr = 16'h8000; #1; check("R1", 'h8000, 1'b1);
    sweep();
    // R2: idle cycles select nothing
    bus_valid = 1'b0;
    for (int a = 0; a < 65536; a += 7) begin
      bus_addr = a[15:0]; #1; check("R2", a, 1'b0);
    end
    bus_valid = 1'b1;
    // block over EEPROM, page 101, debug on
    reg_write('h011, {5'b00011, 3'b000});
    reg_write('h030, 8'h05);
    debug_active = 1'b1;
    sweep();
    // block over fixed flash, page 110
    reg_write('h011, {5'b11111, 3'b000});
    reg_write('h030, 8'h06);
    sweep();
    // block over RAM, page 111, debug off (R8 fall-through)
    reg_write('h011, {5'b00100, 3'b000});
    reg_write('h030, 8'h07);
    debug_active = 1'b0;
    sweep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule